// File: doc/BRIEF.md
# Five-Stage In-Order Load/Store Core

This block is a small in-order processor core with five pipeline stages: fetch, decode, execute, memory and writeback. Each pair of neighbouring stages is separated by an edge-triggered pipeline register. The core has eight general registers and executes add, nand, load word, store word and branch-if-equal, plus halt and no-op. Instruction and data storage are small word-addressed arrays inside the block. They are filled through a shared load port while reset is held.

Operands reach a consumer through forwarding from the two later pipeline registers and through a same-cycle write-to-read bypass in the register file. A load whose result is needed by the very next instruction costs one bubble. Branches are predicted not taken and resolved in the memory stage. When a branch is taken, the three younger instructions are turned into no-ops. A sticky halted flag and a register read port let an outside checker compare the final architectural state with a software model.

Top module: `pipe5_core`

## Requirements
- R1: While reset is asserted and in the first cycle after its release, `halted` is low, the decode pipeline register holds a no-op, and every register reads zero through the read port.
- R2: Instruction fields are: opcode in bits 24-22, first source in bits 21-19, second source in bits 18-16, and a 16-bit signed offset in bits 15-0. Opcode 0 writes first+second and opcode 1 writes the bitwise NOT of (first AND second). Both write to the register named by bits 2-0.
- R3: Opcode 2 loads the data word at address (first source + offset) into the register named by bits 18-16. Opcode 3 stores the second source register to that address. Only the low address bits are used, so addresses wrap within the data array.
- R4: Opcode 4 compares the two sources. When they are equal, the next PC is branch PC+1+offset, taken from the memory stage, and the three instructions fetched after the branch never change registers or memory. When they differ, execution falls through.
- R5: An instruction that depends on a non-load producer one, two or three slots earlier sees the producer's result without any stall.
- R6: A load followed directly by an instruction that reads the load's destination (nonzero) inserts exactly one bubble. No other combination stalls.
- R7: Register 0 always reads zero, and writes to it are ignored.
- R8: Opcode 6 raises `halted` once it reaches writeback, and the flag stays high. No instruction after the halt changes state. Opcodes 5 and 7 do nothing.
- R9: Counted from reset release, `halted` rises at clock edge n+4+3T+S. Here n is the number of instructions executed up to and including the halt, T is the number of taken branches and S is the number of load-use bubbles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Write one word into a storage array this cycle |
| ld_dmem | input | 1 | Select the data array (1) or instruction array (0) for the load port |
| ld_addr | input | MEM_AW | Word address for the load port |
| ld_data | input | XLEN | Word to write; the instruction array keeps bits 24-0 |
| halted | output | 1 | Sticky flag: a halt has retired |
| rf_rd_idx | input | RIDX_W | Register index for the observation port |
| rf_rd_data | output | XLEN | Contents of the selected register |

## Verification
The retirement time of each program is predicted as n+4+3T+S edges after reset release. The bench derives n, T and S from its own instruction-level model of the program, and counts rising edges while sampling `halted` at each falling edge, so the count matches the exact edge where the flag is registered. Register results are read through the read port a few idle cycles after `halted`, which leaves no instruction in flight. Directed programs cover forwarding distances, load-use pairs, backward and forward branches with live shadow instructions, and post-halt work. Sweeps of pseudo-random straight-line programs cover the remaining operand combinations.

// File: rtl/pipe5_pkg.sv
package pipe5_pkg;

   typedef enum logic [2:0] {
      OP_ADD  = 3'd0,
      OP_NAND = 3'd1,
      OP_LW   = 3'd2,
      OP_SW   = 3'd3,
      OP_BEQ  = 3'd4,
      OP_RSVD = 3'd5,
      OP_HALT = 3'd6,
      OP_NOP  = 3'd7
   } opcode_e;

   typedef enum logic [1:0] {
      FWD_RF    = 2'd0,
      FWD_EXMEM = 2'd1,
      FWD_MEMWB = 2'd2
   } fwd_sel_e;

   localparam int IW      = 25;
   localparam int OPC_LSB = 22;
   localparam int SRCA_LSB = 19;
   localparam int SRCB_LSB = 16;

   localparam logic [IW-1:0] NOP_WORD = {OP_NOP, 22'd0};

   function automatic logic op_reads_a(opcode_e op);
      return (op == OP_ADD) || (op == OP_NAND) || (op == OP_LW) ||
             (op == OP_SW)  || (op == OP_BEQ);
   endfunction

   function automatic logic op_reads_b(opcode_e op);
      return (op == OP_ADD) || (op == OP_NAND) || (op == OP_SW) || (op == OP_BEQ);
   endfunction

endpackage

// File: rtl/p5_wordmem.sv
module p5_wordmem #(
   parameter int W  = 32,
   parameter int AW = 6
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [W-1:0]  wdata,
   input  logic [AW-1:0] raddr,
   output logic [W-1:0]  rdata
);
   localparam int DEPTH = 1 << AW;

   if (AW < 1 || AW > 12) begin : g_bad_aw
      $error("p5_wordmem: AW out of range");
   end

   logic [W-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we) cells[waddr] <= wdata;
   end

   assign rdata = cells[raddr];
endmodule

// File: rtl/p5_regfile.sv
module p5_regfile #(
   parameter int XLEN  = 32,
   parameter int IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [IDX_W-1:0] widx,
   input  logic [XLEN-1:0]  wdata,
   input  logic [IDX_W-1:0] ra_idx,
   output logic [XLEN-1:0]  ra_data,
   input  logic [IDX_W-1:0] rb_idx,
   output logic [XLEN-1:0]  rb_data,
   input  logic [IDX_W-1:0] rc_idx,
   output logic [XLEN-1:0]  rc_data
);
   localparam int NREGS = 1 << IDX_W;

   logic [XLEN-1:0] regs [NREGS];

   for (genvar g = 0; g < NREGS; g++) begin : g_reg
      if (g == 0) begin : g_zero
         assign regs[g] = '0;
      end else begin : g_flop
         logic [XLEN-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                             q <= '0;
            else if (we && widx == IDX_W'(g))       q <= wdata;
         end
         assign regs[g] = q;
      end
   end

   logic hit_a, hit_b, hit_c;
   assign hit_a = we && (widx != '0) && (widx == ra_idx);
   assign hit_b = we && (widx != '0) && (widx == rb_idx);
   assign hit_c = we && (widx != '0) && (widx == rc_idx);

   assign ra_data = hit_a ? wdata : regs[ra_idx];
   assign rb_data = hit_b ? wdata : regs[rb_idx];
   assign rc_data = hit_c ? wdata : regs[rc_idx];

   // R7: index zero is hardwired low on every read path
   a_r7_zero_reg: assert property (@(posedge clk) disable iff (!rst_n)
      (ra_idx == '0) |-> (ra_data == '0));
   a_r7_zero_obs: assert property (@(posedge clk) disable iff (!rst_n)
      (rc_idx == '0) |-> (rc_data == '0));
endmodule

// File: rtl/p5_alu.sv
module p5_alu
   import pipe5_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  opcode_e         op,
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   input  logic [XLEN-1:0] off,
   output logic [XLEN-1:0] y
);
   always_comb begin
      unique case (op)
         OP_NAND:      y = ~(a & b);
         OP_LW, OP_SW: y = a + off;
         default:      y = a + b;
      endcase
   end
endmodule

// File: rtl/p5_hazard.sv
module p5_hazard
   import pipe5_pkg::*;
#(
   parameter int IDX_W = 3
) (
   input  opcode_e          id_op,
   input  logic [IDX_W-1:0] id_ra,
   input  logic [IDX_W-1:0] id_rb,
   input  opcode_e          ex_op,
   input  logic [IDX_W-1:0] ex_ra,
   input  logic [IDX_W-1:0] ex_rb,
   input  logic [IDX_W-1:0] ex_dst,
   input  opcode_e          mem_op,
   input  logic [IDX_W-1:0] mem_dst,
   input  logic [IDX_W-1:0] wb_dst,
   output logic             stall,
   output fwd_sel_e         fwd_a,
   output fwd_sel_e         fwd_b
);
   logic ld_in_ex, hit_a, hit_b;
   assign ld_in_ex = (ex_op == OP_LW) && (ex_dst != '0);
   assign hit_a    = op_reads_a(id_op) && (id_ra == ex_dst);
   assign hit_b    = op_reads_b(id_op) && (id_rb == ex_dst);
   assign stall    = ld_in_ex && (hit_a || hit_b);

   function automatic fwd_sel_e pick(logic [IDX_W-1:0] src);
      if (mem_dst != '0 && mem_op != OP_LW && mem_dst == src) return FWD_EXMEM;
      else if (wb_dst != '0 && wb_dst == src)                  return FWD_MEMWB;
      else                                                      return FWD_RF;
   endfunction

   assign fwd_a = pick(ex_ra);
   assign fwd_b = pick(ex_rb);
endmodule

// File: rtl/pipe5_core.sv
module pipe5_core
   import pipe5_pkg::*;
#(
   parameter int XLEN   = 32,
   parameter int MEM_AW = 6,
   parameter int RIDX_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_en,
   input  logic              ld_dmem,
   input  logic [MEM_AW-1:0] ld_addr,
   input  logic [XLEN-1:0]   ld_data,
   output logic              halted,
   input  logic [RIDX_W-1:0] rf_rd_idx,
   output logic [XLEN-1:0]   rf_rd_data
);
   localparam int OFF_W = 16;

   if (XLEN < IW)                       begin : g_bad_xlen $error("pipe5_core: XLEN too small"); end
   if (RIDX_W != 3)                     begin : g_bad_ridx $error("pipe5_core: fields are 3 bits"); end
   if (MEM_AW < 2 || MEM_AW > OFF_W)    begin : g_bad_aw   $error("pipe5_core: MEM_AW range"); end

   typedef struct packed {
      logic [IW-1:0]     instr;
      logic [MEM_AW-1:0] pc1;
   } ifid_t;

   typedef struct packed {
      opcode_e           op;
      logic [RIDX_W-1:0] ra;
      logic [RIDX_W-1:0] rb;
      logic [RIDX_W-1:0] dst;
      logic [XLEN-1:0]   a;
      logic [XLEN-1:0]   b;
      logic [XLEN-1:0]   off;
      logic [MEM_AW-1:0] pc1;
   } idex_t;

   typedef struct packed {
      opcode_e           op;
      logic [RIDX_W-1:0] dst;
      logic [XLEN-1:0]   alu;
      logic [XLEN-1:0]   bval;
      logic [MEM_AW-1:0] target;
      logic              eq;
   } exmem_t;

   typedef struct packed {
      opcode_e           op;
      logic [RIDX_W-1:0] dst;
      logic [XLEN-1:0]   wdata;
   } memwb_t;

   function automatic ifid_t ifid_bubble();
      ifid_t r; r = '0; r.instr = NOP_WORD; return r;
   endfunction
   function automatic idex_t idex_bubble();
      idex_t r; r = '0; r.op = OP_NOP; return r;
   endfunction
   function automatic exmem_t exmem_bubble();
      exmem_t r; r = '0; r.op = OP_NOP; return r;
   endfunction
   function automatic memwb_t memwb_bubble();
      memwb_t r; r = '0; r.op = OP_NOP; return r;
   endfunction

   logic [MEM_AW-1:0] pc_q;
   logic              fetch_stop_q;
   logic              halted_q;
   ifid_t             ifid_q;
   idex_t             idex_q;
   exmem_t            exmem_q;
   memwb_t            memwb_q;

   // ---------------- fetch ----------------
   logic [IW-1:0] imem_rd, fetch_word;
   p5_wordmem #(.W(IW), .AW(MEM_AW)) u_imem (
      .clk(clk), .we(ld_en && !ld_dmem), .waddr(ld_addr), .wdata(ld_data[IW-1:0]),
      .raddr(pc_q), .rdata(imem_rd));
   assign fetch_word = fetch_stop_q ? NOP_WORD : imem_rd;

   logic fetch_is_halt;
   assign fetch_is_halt = (opcode_e'(fetch_word[OPC_LSB +: 3]) == OP_HALT);

   // ---------------- decode ----------------
   opcode_e           id_op;
   logic [RIDX_W-1:0] id_ra, id_rb, id_dlo, id_dst;
   logic [XLEN-1:0]   id_off, id_a, id_b;

   assign id_op  = opcode_e'(ifid_q.instr[OPC_LSB +: 3]);
   assign id_ra  = ifid_q.instr[SRCA_LSB +: RIDX_W];
   assign id_rb  = ifid_q.instr[SRCB_LSB +: RIDX_W];
   assign id_dlo = ifid_q.instr[RIDX_W-1:0];
   assign id_off = {{(XLEN-OFF_W){ifid_q.instr[OFF_W-1]}}, ifid_q.instr[OFF_W-1:0]};

   always_comb begin
      unique case (id_op)
         OP_ADD, OP_NAND: id_dst = id_dlo;
         OP_LW:           id_dst = id_rb;
         default:         id_dst = '0;
      endcase
   end

   p5_regfile #(.XLEN(XLEN), .IDX_W(RIDX_W)) u_rf (
      .clk(clk), .rst_n(rst_n),
      .we(memwb_q.dst != '0), .widx(memwb_q.dst), .wdata(memwb_q.wdata),
      .ra_idx(id_ra), .ra_data(id_a),
      .rb_idx(id_rb), .rb_data(id_b),
      .rc_idx(rf_rd_idx), .rc_data(rf_rd_data));

   // ---------------- hazards ----------------
   logic     stall;
   fwd_sel_e fwd_a, fwd_b;
   p5_hazard #(.IDX_W(RIDX_W)) u_hz (
      .id_op(id_op), .id_ra(id_ra), .id_rb(id_rb),
      .ex_op(idex_q.op), .ex_ra(idex_q.ra), .ex_rb(idex_q.rb), .ex_dst(idex_q.dst),
      .mem_op(exmem_q.op), .mem_dst(exmem_q.dst), .wb_dst(memwb_q.dst),
      .stall(stall), .fwd_a(fwd_a), .fwd_b(fwd_b));

   // ---------------- execute ----------------
   logic [XLEN-1:0] ex_a, ex_b, ex_y;
   always_comb begin
      unique case (fwd_a)
         FWD_EXMEM: ex_a = exmem_q.alu;
         FWD_MEMWB: ex_a = memwb_q.wdata;
         default:   ex_a = idex_q.a;
      endcase
      unique case (fwd_b)
         FWD_EXMEM: ex_b = exmem_q.alu;
         FWD_MEMWB: ex_b = memwb_q.wdata;
         default:   ex_b = idex_q.b;
      endcase
   end

   p5_alu #(.XLEN(XLEN)) u_alu (
      .op(idex_q.op), .a(ex_a), .b(ex_b), .off(idex_q.off), .y(ex_y));

   exmem_t ex_next;
   always_comb begin
      ex_next.op     = idex_q.op;
      ex_next.dst    = idex_q.dst;
      ex_next.alu    = ex_y;
      ex_next.bval   = ex_b;
      ex_next.target = idex_q.pc1 + idex_q.off[MEM_AW-1:0];
      ex_next.eq     = (ex_a == ex_b);
   end

   // ---------------- memory ----------------
   logic              flush, dm_we;
   logic [MEM_AW-1:0] dm_waddr;
   logic [XLEN-1:0]   dm_wdata, dm_rd;
   logic              ld_to_dm;

   assign flush    = (exmem_q.op == OP_BEQ) && exmem_q.eq;
   assign ld_to_dm = ld_en && ld_dmem;
   assign dm_we    = ld_to_dm || (rst_n && exmem_q.op == OP_SW);
   assign dm_waddr = ld_to_dm ? ld_addr : exmem_q.alu[MEM_AW-1:0];
   assign dm_wdata = ld_to_dm ? ld_data : exmem_q.bval;

   p5_wordmem #(.W(XLEN), .AW(MEM_AW)) u_dmem (
      .clk(clk), .we(dm_we), .waddr(dm_waddr), .wdata(dm_wdata),
      .raddr(exmem_q.alu[MEM_AW-1:0]), .rdata(dm_rd));

   memwb_t mem_next;
   always_comb begin
      mem_next.op    = exmem_q.op;
      mem_next.dst   = exmem_q.dst;
      mem_next.wdata = (exmem_q.op == OP_LW) ? dm_rd : exmem_q.alu;
   end

   // ---------------- pipeline registers ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q         <= '0;
         fetch_stop_q <= 1'b0;
         halted_q     <= 1'b0;
         ifid_q       <= ifid_bubble();
         idex_q       <= idex_bubble();
         exmem_q      <= exmem_bubble();
         memwb_q      <= memwb_bubble();
      end else begin
         memwb_q  <= mem_next;
         halted_q <= halted_q || (memwb_q.op == OP_HALT);
         if (flush) begin
            pc_q         <= exmem_q.target;
            fetch_stop_q <= 1'b0;
            ifid_q       <= ifid_bubble();
            idex_q       <= idex_bubble();
            exmem_q      <= exmem_bubble();
         end else if (stall) begin
            idex_q  <= idex_bubble();
            exmem_q <= ex_next;
         end else begin
            if (!fetch_stop_q) pc_q <= pc_q + MEM_AW'(1);
            if (fetch_is_halt) fetch_stop_q <= 1'b1;
            ifid_q.instr <= fetch_word;
            ifid_q.pc1   <= pc_q + MEM_AW'(1);
            idex_q.op    <= id_op;
            idex_q.ra    <= id_ra;
            idex_q.rb    <= id_rb;
            idex_q.dst   <= id_dst;
            idex_q.a     <= id_a;
            idex_q.b     <= id_b;
            idex_q.off   <= id_off;
            idex_q.pc1   <= ifid_q.pc1;
            exmem_q      <= ex_next;
         end
      end
   end

   assign halted = halted_q;

   // R1: first cycle out of reset starts idle
   a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> (!halted_q && opcode_e'(ifid_q.instr[OPC_LSB +: 3]) == OP_NOP));
   // R4: a taken branch leaves three empty slots behind it
   a_r4_flush_squash: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (idex_q.op == OP_NOP && exmem_q.op == OP_NOP &&
                 opcode_e'(ifid_q.instr[OPC_LSB +: 3]) == OP_NOP));
   // R6: a load-use stall holds fetch and inserts one bubble
   a_r6_stall_bubble: assert property (@(posedge clk) disable iff (!rst_n)
      (stall && !flush) |=> (idex_q.op == OP_NOP && $stable(pc_q)));
   // R8: the halted flag never drops while running
   a_r8_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      halted_q |=> halted_q);
endmodule

// File: tb/test_pipe5_core.sv
module test_pipe5_core;
   localparam int XLEN = 32;
   localparam int AW   = 6;
   localparam int DEPTH = 1 << AW;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            ld_en = 1'b0;
   logic            ld_dmem = 1'b0;
   logic [AW-1:0]   ld_addr = '0;
   logic [XLEN-1:0] ld_data = '0;
   logic            halted;
   logic [2:0]      rf_rd_idx = '0;
   logic [XLEN-1:0] rf_rd_data;

   always #10 clk = ~clk;

   pipe5_core #(.XLEN(XLEN), .MEM_AW(AW), .RIDX_W(3)) i_pipe5_core (
      .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_dmem(ld_dmem),
      .ld_addr(ld_addr), .ld_data(ld_data), .halted(halted),
      .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data));

   int  n_checks = 0;
   int  n_fail   = 0;
   bit  finished = 0;

   logic [31:0] prog  [DEPTH];
   logic [31:0] dinit [DEPTH];
   logic [31:0] m_rf  [8];
   logic [31:0] m_dm  [DEPTH];
   int          m_cycles;
   logic [31:0] rng;

   function automatic logic [31:0] enc(int op, int ra, int rb, int lo);
      return {7'd0, op[2:0], ra[2:0], rb[2:0], lo[15:0]};
   endfunction

   function automatic logic [31:0] next_rng(logic [31:0] s);
      logic [31:0] x = s;
      x = x ^ (x << 13);
      x = x ^ (x >> 17);
      x = x ^ (x << 5);
      return x;
   endfunction

   task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // instruction-level reference with its own cycle estimate
   task automatic model_run();
      int pc = 0, n = 0, taken = 0, stalls = 0, ld_dst = 0;
      for (int i = 0; i < 8; i++) m_rf[i] = '0;
      for (int i = 0; i < DEPTH; i++) m_dm[i] = dinit[i];
      for (int step = 0; step < 5000; step++) begin
         logic [31:0] w = prog[pc];
         int op = int'(w[24:22]);
         int ra = int'(w[21:19]);
         int rb = int'(w[18:16]);
         int dl = int'(w[2:0]);
         logic [31:0] off = {{16{w[15]}}, w[15:0]};
         logic [31:0] adr = m_rf[ra] + off;
         n++;
         if (ld_dst != 0) begin
            bit ua = (op <= 4);
            bit ub = (op == 0 || op == 1 || op == 3 || op == 4);
            if ((ua && ra == ld_dst) || (ub && rb == ld_dst)) stalls++;
         end
         ld_dst = 0;
         if (op == 6) break;
         case (op)
            0: if (dl != 0) m_rf[dl] = m_rf[ra] + m_rf[rb];
            1: if (dl != 0) m_rf[dl] = ~(m_rf[ra] & m_rf[rb]);
            2: begin if (rb != 0) m_rf[rb] = m_dm[adr[AW-1:0]]; ld_dst = rb; end
            3: m_dm[adr[AW-1:0]] = m_rf[rb];
            default: ;
         endcase
         if (op == 4 && m_rf[ra] == m_rf[rb]) begin
            pc = (pc + 1 + int'($signed(w[15:0]))) & (DEPTH - 1);
            taken++;
         end else begin
            pc = (pc + 1) & (DEPTH - 1);
         end
      end
      m_cycles = n + 4 + 3 * taken + stalls;
   endtask

   task automatic read_reg(int idx, output logic [31:0] v);
      rf_rd_idx = idx[2:0];
      #1;
      v = rf_rd_data;
   endtask

   task automatic run_prog(string tag_rf, string tag_cyc);
      logic [31:0] v;
      int cyc = 0;
      @(negedge clk);
      rst_n = 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
         @(negedge clk);
         ld_en = 1'b1; ld_dmem = 1'b0; ld_addr = AW'(i); ld_data = prog[i];
      end
      for (int i = 0; i < DEPTH; i++) begin
         @(negedge clk);
         ld_en = 1'b1; ld_dmem = 1'b1; ld_addr = AW'(i); ld_data = dinit[i];
      end
      @(negedge clk);
      ld_en = 1'b0;
      chk(halted == 1'b0, "R1", "halted in reset", {31'd0, halted}, 32'd0);
      for (int i = 0; i < 8; i++) begin
         read_reg(i, v);
         chk(v == 32'd0, "R1", $sformatf("r%0d in reset", i), v, 32'd0);
      end
      model_run();
      @(negedge clk);
      rst_n = 1'b1;
      while (cyc < 4000) begin
         @(posedge clk);
         cyc++;
         @(negedge clk);
         if (halted) break;
      end
      chk(halted == 1'b1, "R8", "halted raised", {31'd0, halted}, 32'd1);
      chk(cyc == m_cycles, tag_cyc, "edges to halted", cyc, m_cycles);
      repeat (6) @(negedge clk);
      chk(halted == 1'b1, "R8", "halted sticky", {31'd0, halted}, 32'd1);
      for (int i = 0; i < 8; i++) begin
         read_reg(i, v);
         chk(v == m_rf[i], (i == 0) ? "R7" : tag_rf, $sformatf("r%0d final", i), v, m_rf[i]);
      end
   endtask

   task automatic fill_default();
      for (int i = 0; i < DEPTH; i++) begin
         prog[i]  = enc(6, 0, 0, 0);
         dinit[i] = 32'h1000_0000 + 32'(i * 7);
      end
   endtask

   initial begin
      rng = 32'h2468_ACE1;

      // R2/R5/R6/R7: arithmetic, forwarding at distances 1..3, load-use, r0 writes
      fill_default();
      dinit[1] = 32'h0000_00F0;
      dinit[2] = 32'h0000_0F0F;
      prog[0] = enc(2, 0, 1, 1);     // r1 = dm[1]
      prog[1] = enc(2, 0, 2, 2);     // r2 = dm[2]
      prog[2] = enc(0, 1, 2, 3);     // r3 = r1+r2 (load-use)
      prog[3] = enc(1, 3, 1, 4);     // r4 = nand(r3,r1), distance 1
      prog[4] = enc(0, 3, 4, 5);     // r5 = r3+r4, distances 2 and 1
      prog[5] = enc(0, 1, 2, 0);     // write to r0 ignored
      prog[6] = enc(0, 3, 0, 6);     // r6 = r3 + r0, distance 4
      prog[7] = enc(0, 5, 6, 7);     // r7 = r5+r6
      prog[8] = enc(0, 7, 0, 0);     // r0 again
      prog[9] = enc(0, 0, 7, 1);     // r1 = r0 + r7
      run_prog("R2", "R6");

      // R4: counted loop, backward and forward branches, shadow instructions
      fill_default();
      dinit[10] = 32'd5;
      dinit[11] = 32'hFFFF_FFFF;
      prog[0]  = enc(2, 0, 1, 10);   // r1 = 5
      prog[1]  = enc(2, 0, 2, 11);   // r2 = -1
      prog[2]  = enc(0, 3, 1, 3);    // r3 += r1
      prog[3]  = enc(0, 1, 2, 1);    // r1 += r2
      prog[4]  = enc(4, 1, 0, 5);    // exit when r1 == 0 -> 10
      prog[5]  = enc(4, 0, 0, -4);   // always back to 2
      prog[6]  = enc(0, 1, 1, 7);    // shadow, must not commit
      prog[7]  = enc(0, 1, 1, 6);
      prog[8]  = enc(3, 0, 1, 40);
      prog[9]  = enc(0, 1, 1, 5);
      prog[10] = enc(2, 0, 4, 40);   // r4 = dm[40], untouched by shadow store
      prog[11] = enc(6, 0, 0, 0);
      prog[12] = enc(0, 1, 1, 7);
      run_prog("R4", "R4");

      // R3/R8: store/load round trip, wrap, work after halt
      fill_default();
      dinit[3] = 32'h8000_0001;
      prog[0] = enc(2, 0, 1, 3);     // r1 = dm[3]
      prog[1] = enc(3, 0, 1, 20);    // dm[20] = r1 (load-use on store data)
      prog[2] = enc(2, 0, 2, 20);    // r2 = dm[20]
      prog[3] = enc(0, 2, 2, 4);     // r4 = r2+r2
      prog[4] = enc(3, 0, 4, -2);    // dm[62] = r4 (wrap)
      prog[5] = enc(2, 0, 5, 62);    // r5 = dm[62]
      prog[6] = enc(7, 1, 2, 3);     // noop
      prog[7] = enc(5, 1, 2, 3);     // reserved, no effect
      prog[8] = enc(6, 0, 0, 0);     // halt
      prog[9] = enc(0, 5, 5, 6);     // must not commit
      prog[10] = enc(3, 0, 5, 30);
      prog[11] = enc(2, 0, 7, 30);
      run_prog("R3", "R8");

      // R5/R9 sweep: pseudo-random straight-line programs
      for (int s = 0; s < 20; s++) begin
         fill_default();
         for (int i = 0; i < DEPTH; i++) begin
            rng = next_rng(rng);
            dinit[i] = rng;
         end
         for (int i = 0; i < 48; i++) begin
            int kind, ra, rb, dl, off;
            rng = next_rng(rng);
            kind = int'(rng[2:0]) % 5;
            ra = int'(rng[5:3]);
            rb = int'(rng[8:6]);
            dl = int'(rng[11:9]);
            off = int'(rng[15:12]) - 8;
            case (kind)
               0: prog[i] = enc(0, ra, rb, dl);
               1: prog[i] = enc(1, ra, rb, dl);
               2: prog[i] = enc(2, ra, rb, off);
               3: prog[i] = enc(3, ra, rb, off);
               default: prog[i] = enc(7, 0, 0, 0);
            endcase
         end
         run_prog("R5", "R9");
      end

      if (!finished) begin
         finished = 1;
         $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end
endmodule